// File: doc/BRIEF.md
# Timer Frame Access Control Unit

This block sits in front of up to eight timer frames and decides, one register at a time, whether a bus access reaches the frame or is turned into a reserved-zero access. Reserved-zero means that reads return zero and writes are dropped. Each frame has a six-bit permission word held in a control frame. Software reaches that word through a small register-bus slave port. The counters and comparators themselves live outside the block, in a register file that is reached only through the filter outputs.

The permission word splits a frame's registers into classes. Four classes are read-only: physical count, virtual count, frequency and virtual offset. Two are read/write groups: the virtual timer group and the physical timer group. Access to the permission word itself depends on three things: the request's security attribute, a per-frame non-secure permit vector, and a per-frame implemented vector. Build parameters can fix any grant bit to always-denied or always-permitted.

The control port runs a two-state machine. In `ST_IDLE` a request is accepted (transition IDLE_ACCEPT) and the machine moves to `ST_RESP`. In `ST_RESP` the acknowledge and read data are presented for exactly one cycle, and the machine returns unconditionally (transition RESP_DONE). The frame filter path is purely combinational.

Top module: `tmr_frame_guard`

## Requirements
- R1: Frame n's permission word sits at control offset 0x040 + 4*n, for n below NUM_FRAMES. Its bit 0 grants physical count, bit 1 virtual count, bit 2 frequency, bit 3 virtual offset, bit 4 the virtual timer group and bit 5 the physical timer group.
- R2: Bits 31:6 of every permission word read as zero, and written values in those bits are dropped.
- R3: Configurable grant bits are 0 after reset.
- R4: A filter read returns `rf_rdata` only when the selected register's grant bit is 1. Otherwise it returns zero. The register select codes are: 0 physical count, 1 virtual count, 2 frequency, 3 virtual offset, 4–6 virtual timer compare/value/control, 7–9 physical timer compare/value/control. Codes 10–15 are unmapped and always return zero.
- R5: `rf_we` is never asserted for a register whose grant bit is 0, nor for an unmapped select code.
- R6: Select codes 0–3 are never written, even when granted. Codes 4–9 raise `rf_we` in the same cycle as a granted write request.
- R7: A secure request always reaches an implemented frame's permission word. A non-secure request reaches it only when that frame's `ns_permit` bit is 1; otherwise it reads zero and its write is dropped.
- R8: For a frame whose `frame_impl` bit is 0, the permission slot reads zero and drops writes, and every filter access to that frame is denied.
- R9: When FIXED_MASK bit b is set, grant bit b reads as FIXED_VAL bit b in every implemented frame, acts that way in the filter, and ignores writes.
- R10: Control offsets that are not an aligned permission slot read zero and drop writes. This covers misaligned offsets, offsets below 0x040, and offsets past the last frame.
- R11: A request accepted in ST_IDLE is answered by `ctl_ack` high for exactly one cycle. For a read, `ctl_rdata` then carries the value; for a write it carries zero. A request held during ST_RESP is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_req | input | 1 | Control port request |
| ctl_write | input | 1 | 1 = write, 0 = read |
| ctl_secure | input | 1 | 1 = secure request |
| ctl_addr | input | ADDR_W | Control frame byte offset |
| ctl_wdata | input | DATA_W | Control write data |
| ctl_ack | output | 1 | One-cycle response strobe |
| ctl_rdata | output | DATA_W | Control read data, valid with ack |
| frame_impl | input | NUM_FRAMES | Per-frame implemented flags |
| ns_permit | input | NUM_FRAMES | Per-frame non-secure permit for the permission word |
| frm_req | input | 1 | Frame access request |
| frm_write | input | 1 | 1 = write |
| frm_frame | input | IDX_W | Target frame index |
| frm_sel | input | 4 | Register select code |
| frm_wdata | input | DATA_W | Frame write data |
| frm_rdata | output | DATA_W | Gated frame read data |
| rf_we | output | 1 | Write strobe to the register file |
| rf_frame | output | IDX_W | Frame index to the register file |
| rf_sel | output | 4 | Register select to the register file |
| rf_wdata | output | DATA_W | Write data to the register file |
| rf_rdata | input | DATA_W | Register file read data |

## Verification
Several properties are checked on every cycle:
- `ctl_ack` is a single-cycle pulse.
- Response data is zero outside a response.
- The permission store is never written for an unimplemented frame or outside ST_IDLE.
- `rf_we` only ever rises for a writable, granted register class.
- A denied read yields zero.

Other behaviours are visible only through the bench's ordered scenarios:
- How the grant values are composed from fixed and configurable bits.
- The non-secure blocking of particular frames.
- Dropped reserved bits and misaligned offsets.
- A request held through ST_RESP being ignored.

// File: rtl/tfg_pkg.sv
package tfg_pkg;
    localparam int GRANT_W = 6;
    localparam int SEL_W   = 4;
    typedef logic [GRANT_W-1:0] grant_t;
    typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_RESP = 1'b1} ctl_state_e;
    // grant bit positions; neighbours decode these
    localparam int GB_VTIMER = 4;
    localparam int GB_PTIMER = 5;
endpackage

// File: rtl/tfg_perm_bank.sv
module tfg_perm_bank
    import tfg_pkg::*;
#(
    parameter int     NUM_FRAMES = 8,
    parameter grant_t FIXED_MASK = '0,
    parameter grant_t FIXED_VAL  = '0,
    localparam int    IDX_W      = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  grant_t                       wr_bits,
    input  logic [NUM_FRAMES-1:0]        frame_impl,
    output grant_t [NUM_FRAMES-1:0]      grant_o
);
    grant_t eff [NUM_FRAMES];

    for (genvar f = 0; f < NUM_FRAMES; f++) begin : g_frame
        for (genvar b = 0; b < GRANT_W; b++) begin : g_bit
            if (FIXED_MASK[b]) begin : g_fixed
                assign eff[f][b] = FIXED_VAL[b];
            end else begin : g_cfg
                logic bit_q;
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)
                        bit_q <= 1'b0;
                    else if (wr_en && (wr_idx == IDX_W'(f)))
                        bit_q <= wr_bits[b];
                end
                assign eff[f][b] = bit_q;
            end
        end
        assign grant_o[f] = frame_impl[f] ? eff[f] : '0;
    end

    // R8: the control port never writes into an unimplemented slot
    always_comb begin
        if (rst_n && wr_en)
            assert_no_unimpl_write_R8: assert (frame_impl[wr_idx]);
    end
endmodule

// File: rtl/tfg_ctl_port.sv
module tfg_ctl_port
    import tfg_pkg::*;
#(
    parameter int NUM_FRAMES = 8,
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 32,
    parameter int BASE_OFF   = 'h040,
    localparam int IDX_W     = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1,
    localparam int LAST_OFF  = BASE_OFF + 4 * NUM_FRAMES
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req,
    input  logic                    write,
    input  logic                    secure,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [DATA_W-1:0]       wdata,
    input  logic [NUM_FRAMES-1:0]   frame_impl,
    input  logic [NUM_FRAMES-1:0]   ns_permit,
    input  grant_t [NUM_FRAMES-1:0] grant_i,
    output logic                    ack,
    output logic [DATA_W-1:0]       rdata,
    output logic                    wr_en,
    output logic [IDX_W-1:0]        wr_idx,
    output grant_t                  wr_bits
);
    ctl_state_e          state_q, state_d;
    logic [DATA_W-1:0]   rdata_q, rd_val;
    logic [ADDR_W-1:0]   off;
    logic [IDX_W-1:0]    idx;
    logic                hit, allowed, accept;
    logic                unused_wdata;

    assign unused_wdata = ^wdata[DATA_W-1:GRANT_W];
    assign off = addr - ADDR_W'(BASE_OFF);
    assign idx = IDX_W'(off >> 2);
    assign hit = (addr >= ADDR_W'(BASE_OFF)) && (addr < ADDR_W'(LAST_OFF))
                 && (addr[1:0] == 2'b00);
    assign allowed = hit && frame_impl[idx] && (secure || ns_permit[idx]);
    assign accept  = req && (state_q == ST_IDLE);

    assign wr_en   = accept && write && allowed;
    assign wr_idx  = idx;
    assign wr_bits = wdata[GRANT_W-1:0];
    assign rd_val  = (allowed && !write) ? DATA_W'(grant_i[idx]) : '0;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            rdata_q <= accept ? rd_val : '0;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        ack     = 1'b0;
        unique case (state_q)
            ST_IDLE: if (req) state_d = ST_RESP;   // IDLE_ACCEPT
            ST_RESP: begin
                ack     = 1'b1;
                state_d = ST_IDLE;                 // RESP_DONE
            end
            default: state_d = ST_IDLE;
        endcase
    end
    assign rdata = rdata_q;

    assert_ack_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
    assert_rdata_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |-> (rdata == '0));
    assert_no_write_in_resp_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> !wr_en);
    assert_ns_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !secure && hit && !ns_permit[idx]) |-> !wr_en);
endmodule

// File: rtl/tfg_filter.sv
module tfg_filter
    import tfg_pkg::*;
#(
    parameter int NUM_FRAMES = 8,
    parameter int DATA_W     = 32,
    localparam int IDX_W     = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
    input  grant_t [NUM_FRAMES-1:0] grant_i,
    input  logic                    frm_req,
    input  logic                    frm_write,
    input  logic [IDX_W-1:0]        frm_frame,
    input  logic [SEL_W-1:0]        frm_sel,
    input  logic [DATA_W-1:0]       frm_wdata,
    output logic [DATA_W-1:0]       frm_rdata,
    input  logic [DATA_W-1:0]       rf_rdata,
    output logic                    rf_we,
    output logic [IDX_W-1:0]        rf_frame,
    output logic [SEL_W-1:0]        rf_sel,
    output logic [DATA_W-1:0]       rf_wdata
);
    logic [2:0] gbit;
    logic       sel_ok, sel_rw, frame_ok, granted;

    always_comb begin
        gbit   = 3'd0;
        sel_ok = 1'b1;
        sel_rw = 1'b0;
        unique case (frm_sel)
            4'd0, 4'd1, 4'd2, 4'd3: gbit = frm_sel[2:0];
            4'd4, 4'd5, 4'd6: begin gbit = 3'(GB_VTIMER); sel_rw = 1'b1; end
            4'd7, 4'd8, 4'd9: begin gbit = 3'(GB_PTIMER); sel_rw = 1'b1; end
            default: sel_ok = 1'b0;
        endcase
    end

    assign frame_ok  = (32'(frm_frame) < NUM_FRAMES);
    assign granted   = sel_ok && frame_ok && grant_i[frm_frame][gbit];
    assign frm_rdata = (frm_req && !frm_write && granted) ? rf_rdata : '0;
    assign rf_we     = frm_req && frm_write && granted && sel_rw;
    assign rf_frame  = frm_frame;
    assign rf_sel    = frm_sel;
    assign rf_wdata  = frm_wdata;

    always_comb begin
        if (rf_we)
            assert_we_rw_class_R6: assert (frm_sel >= 4'd4 && frm_sel <= 4'd9);
        if (frm_req && !frm_write && !granted)
            assert_deny_zero_R4: assert (frm_rdata == '0);
    end
endmodule

// File: rtl/tmr_frame_guard.sv
module tmr_frame_guard
    import tfg_pkg::*;
#(
    parameter int     NUM_FRAMES = 8,
    parameter int     ADDR_W     = 12,
    parameter int     DATA_W     = 32,
    parameter int     BASE_OFF   = 'h040,
    parameter grant_t FIXED_MASK = '0,
    parameter grant_t FIXED_VAL  = '0,
    localparam int    IDX_W      = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ctl_req,
    input  logic                  ctl_write,
    input  logic                  ctl_secure,
    input  logic [ADDR_W-1:0]     ctl_addr,
    input  logic [DATA_W-1:0]     ctl_wdata,
    output logic                  ctl_ack,
    output logic [DATA_W-1:0]     ctl_rdata,
    input  logic [NUM_FRAMES-1:0] frame_impl,
    input  logic [NUM_FRAMES-1:0] ns_permit,
    input  logic                  frm_req,
    input  logic                  frm_write,
    input  logic [IDX_W-1:0]      frm_frame,
    input  logic [3:0]            frm_sel,
    input  logic [DATA_W-1:0]     frm_wdata,
    output logic [DATA_W-1:0]     frm_rdata,
    output logic                  rf_we,
    output logic [IDX_W-1:0]      rf_frame,
    output logic [3:0]            rf_sel,
    output logic [DATA_W-1:0]     rf_wdata,
    input  logic [DATA_W-1:0]     rf_rdata
);
    grant_t [NUM_FRAMES-1:0] grants;
    logic                    wr_en;
    logic [IDX_W-1:0]        wr_idx;
    grant_t                  wr_bits;

    tfg_ctl_port #(.NUM_FRAMES(NUM_FRAMES), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                   .BASE_OFF(BASE_OFF)) u_ctl (
        .clk(clk), .rst_n(rst_n), .req(ctl_req), .write(ctl_write),
        .secure(ctl_secure), .addr(ctl_addr), .wdata(ctl_wdata),
        .frame_impl(frame_impl), .ns_permit(ns_permit), .grant_i(grants),
        .ack(ctl_ack), .rdata(ctl_rdata), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_bits(wr_bits));

    tfg_perm_bank #(.NUM_FRAMES(NUM_FRAMES), .FIXED_MASK(FIXED_MASK),
                    .FIXED_VAL(FIXED_VAL)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_bits(wr_bits), .frame_impl(frame_impl), .grant_o(grants));

    tfg_filter #(.NUM_FRAMES(NUM_FRAMES), .DATA_W(DATA_W)) u_flt (
        .grant_i(grants), .frm_req(frm_req), .frm_write(frm_write),
        .frm_frame(frm_frame), .frm_sel(frm_sel), .frm_wdata(frm_wdata),
        .frm_rdata(frm_rdata), .rf_rdata(rf_rdata), .rf_we(rf_we),
        .rf_frame(rf_frame), .rf_sel(rf_sel), .rf_wdata(rf_wdata));

    // R5: with every grant bit clear no write may reach the register file
    assert_denied_no_we_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_req && frm_write && (32'(frm_frame) < NUM_FRAMES)
         && (grants[frm_frame] == '0)) |-> !rf_we);
endmodule

// File: tb/tmr_frame_guard_tb_top.sv
module tmr_frame_guard_tb_top;
    localparam int NF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_req = 0, ctl_write = 0, ctl_secure = 0;
    logic [11:0] ctl_addr = '0;
    logic [31:0] ctl_wdata = '0;
    logic        ctl_ack;
    logic [31:0] ctl_rdata;
    logic [7:0]  frame_impl = 8'b0111_1111;
    logic [7:0]  ns_permit  = 8'b0000_0101;
    logic        frm_req = 0, frm_write = 0;
    logic [2:0]  frm_frame = '0;
    logic [3:0]  frm_sel = '0;
    logic [31:0] frm_wdata = '0, frm_rdata, rf_wdata, rf_rdata = '0;
    logic        rf_we;
    logic [2:0]  rf_frame;
    logic [3:0]  rf_sel;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    // bit 3 fixed denied, bit 2 fixed permitted
    tmr_frame_guard #(.NUM_FRAMES(NF), .FIXED_MASK(6'b001100),
                      .FIXED_VAL(6'b000100)) dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_req(ctl_req), .ctl_write(ctl_write),
        .ctl_secure(ctl_secure), .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata),
        .ctl_ack(ctl_ack), .ctl_rdata(ctl_rdata), .frame_impl(frame_impl),
        .ns_permit(ns_permit), .frm_req(frm_req), .frm_write(frm_write),
        .frm_frame(frm_frame), .frm_sel(frm_sel), .frm_wdata(frm_wdata),
        .frm_rdata(frm_rdata), .rf_we(rf_we), .rf_frame(rf_frame),
        .rf_sel(rf_sel), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata));

    typedef struct packed {
        logic        wr;
        logic        sec;
        logic [11:0] addr;
        logic [31:0] wdata;
        logic [31:0] exp;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b1, 12'h040, 32'h0,        32'h04, 4'd3},  // R3 R9 reset value
        '{1'b1, 1'b1, 12'h040, 32'hFFFF_FFFF, 32'h0,  4'd2},  // R2 write all ones
        '{1'b0, 1'b1, 12'h040, 32'h0,        32'h37, 4'd2},  // R2 R9 upper dropped
        '{1'b1, 1'b0, 12'h044, 32'h3F,       32'h0,  4'd7},  // R7 ns blocked write
        '{1'b0, 1'b1, 12'h044, 32'h0,        32'h04, 4'd7},  // R7 unchanged
        '{1'b0, 1'b0, 12'h040, 32'h0,        32'h37, 4'd7},  // R7 ns permitted read
        '{1'b0, 1'b0, 12'h044, 32'h0,        32'h0,  4'd7},  // R7 ns blocked read
        '{1'b1, 1'b0, 12'h048, 32'h11,       32'h0,  4'd7},  // R7 ns permitted write
        '{1'b0, 1'b1, 12'h048, 32'h0,        32'h15, 4'd1},  // R1 frame 2 slot
        '{1'b1, 1'b1, 12'h05C, 32'h3F,       32'h0,  4'd8},  // R8 unimplemented
        '{1'b0, 1'b1, 12'h05C, 32'h0,        32'h0,  4'd8},  // R8
        '{1'b0, 1'b1, 12'h060, 32'h0,        32'h0,  4'd10}, // R10 past end
        '{1'b1, 1'b1, 12'h045, 32'h3F,       32'h0,  4'd10}, // R10 misaligned
        '{1'b0, 1'b1, 12'h044, 32'h0,        32'h04, 4'd10}, // R10 untouched
        '{1'b1, 1'b1, 12'h000, 32'h3F,       32'h0,  4'd10}, // R10 below base
        '{1'b0, 1'b1, 12'h000, 32'h0,        32'h0,  4'd10}, // R10
        '{1'b1, 1'b1, 12'h04C, 32'h20,       32'h0,  4'd1},  // R1 frame 3
        '{1'b0, 1'b1, 12'h04C, 32'h0,        32'h24, 4'd1}   // R1
    };

    task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
        end
    endtask

    task automatic ctl_op(input logic w, input logic s, input logic [11:0] a,
                          input logic [31:0] d, input logic [31:0] exp,
                          input string rq);
        @(negedge clk);
        ctl_req = 1; ctl_write = w; ctl_secure = s; ctl_addr = a; ctl_wdata = d;
        @(posedge clk);
        @(negedge clk);
        chk(ctl_ack == 1'b1, {rq, " ack"}, 32'(ctl_ack), 32'h1);
        chk(ctl_rdata == exp, rq, ctl_rdata, exp);
        ctl_req = 0;
    endtask

    task automatic flt(input logic [2:0] f, input logic [3:0] s, input logic w,
                       input logic [31:0] rfd, input logic [31:0] exp_rd,
                       input logic exp_we, input string rq);
        @(negedge clk);
        frm_req = 1; frm_frame = f; frm_sel = s; frm_write = w;
        rf_rdata = rfd; frm_wdata = 32'hC0DE_0000 | 32'(s);
        #1;
        chk(frm_rdata == exp_rd, {rq, " rdata"}, frm_rdata, exp_rd);
        chk(rf_we == exp_we, {rq, " we"}, 32'(rf_we), 32'(exp_we));
        frm_req = 0;
    endtask

    initial begin
        @(negedge clk);
        chk(ctl_ack == 1'b0 && ctl_rdata == '0, "R11 reset", ctl_rdata, 32'h0);
        @(negedge clk);
        rst_n = 1;

        for (int i = 0; i < NV; i++)
            ctl_op(VEC[i].wr, VEC[i].sec, VEC[i].addr, VEC[i].wdata, VEC[i].exp,
                   $sformatf("R%0d vec%0d", VEC[i].rq, i));

        // R11: request held through ST_RESP is ignored
        @(negedge clk);
        ctl_req = 1; ctl_write = 1; ctl_secure = 1; ctl_addr = 12'h050;
        ctl_wdata = 32'h01;
        @(posedge clk); @(negedge clk);
        chk(ctl_ack == 1'b1, "R11 accept", 32'(ctl_ack), 32'h1);
        ctl_wdata = 32'h02;
        @(posedge clk); @(negedge clk);
        chk(ctl_ack == 1'b0, "R11 resp ignores req", 32'(ctl_ack), 32'h0);
        ctl_req = 0;
        ctl_op(1'b0, 1'b1, 12'h050, 32'h0, 32'h05, "R11 held value");

        // grants: f0=0x37 f1=0x04 f2=0x15 f3=0x24 f4=0x05 f7 unimplemented
        flt(3'd0, 4'd0, 1'b0, 32'hA5A5, 32'hA5A5, 1'b0, "R4 granted read");
        flt(3'd1, 4'd0, 1'b0, 32'hA5A5, 32'h0,    1'b0, "R4 denied read");
        flt(3'd1, 4'd2, 1'b0, 32'h1234, 32'h1234, 1'b0, "R9 fixed permit");
        flt(3'd0, 4'd3, 1'b0, 32'h1234, 32'h0,    1'b0, "R9 fixed deny");
        flt(3'd0, 4'd0, 1'b1, 32'h0,    32'h0,    1'b0, "R6 read-only write");
        flt(3'd0, 4'd5, 1'b1, 32'h0,    32'h0,    1'b1, "R6 vtimer write");
        flt(3'd1, 4'd4, 1'b1, 32'h0,    32'h0,    1'b0, "R5 vtimer denied");
        flt(3'd3, 4'd8, 1'b1, 32'h0,    32'h0,    1'b1, "R6 ptimer write");
        flt(3'd2, 4'd9, 1'b1, 32'h0,    32'h0,    1'b0, "R5 ptimer denied");
        flt(3'd2, 4'd6, 1'b0, 32'h77,   32'h77,   1'b0, "R4 vtimer read");
        flt(3'd7, 4'd2, 1'b0, 32'h99,   32'h0,    1'b0, "R8 unimplemented frame");
        flt(3'd0, 4'd12, 1'b0, 32'h99,  32'h0,    1'b0, "R4 unmapped read");
        flt(3'd0, 4'd12, 1'b1, 32'h0,   32'h0,    1'b0, "R5 unmapped write");

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule